// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the logic core of a field-configurable sum-of-products device. Each of its 22 array inputs enters the array as a pair of literals, true and inverted, giving 44 columns. Every output owns eight logic product terms, ORed into one sum, and one extra product term that serves as its output-enable condition. With 10 outputs that is 90 term rows. The block delivers the 10 sums and the 10 enable terms. Output cells, pads and registers that feed state back belong to the surrounding logic. Such fed-back signals simply arrive on some of the array inputs.

The connection map is held in flops, two bits per term per input. A configuration port writes one whole 44-bit term row in a clock cycle and can erase the whole map in a single cycle. In the erased state every term is tied to both literals of every input, so it can never be true. The array itself is purely combinational from its inputs and the stored map. Writes should be made while the outputs are not in use.

Top module: `pal_and_or_array`

## Requirements
- R1: After a synchronous active-low reset every row is erased (all bits 1), so all `sum_out` and `oe_out` bits are 0.
- R2: In a term row, bit 2i+1 ties the true literal of `arr_in[i]` to the term and bit 2i ties the inverted literal. A pair of 10 means the term needs `arr_in[i]`=1, 01 means it needs `arr_in[i]`=0, and 00 leaves input i out. The term is the AND of all literals tied to it.
- R3: A pair of 11 for any input forces its term to 0, whatever the inputs are.
- R4: A row with every pair at 00 evaluates to 1.
- R5: Row index o*9+k, with k from 0 to 7, is logic term k of output o. Row o*9+8 is the enable term of output o.
- R6: `sum_out[o]` is the OR of the eight logic terms of output o. `oe_out[o]` equals its enable term.
- R7: When `cfg_we` is 1 at a clock edge, `cfg_data` replaces row `cfg_row` from the next cycle on. All other rows are left unchanged.
- R8: When `cfg_erase` is 1 at a clock edge, every row becomes all ones from the next cycle. This holds even if `cfg_we` is also 1.
- R9: A write with `cfg_row` of 90 or more changes no row.
- R10: The outputs follow `arr_in` within the same cycle, with no clock edge in between. This allows registered outputs to be fed back as inputs to form next-state logic.
- R11: In a cycle with neither `cfg_we` nor `cfg_erase`, the outputs do not change unless `arr_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset, erases the map |
| cfg_we | input | 1 | Write one term row |
| cfg_erase | input | 1 | Erase the whole map |
| cfg_row | input | 7 | Term row index, 0 to 89 valid |
| cfg_data | input | 44 | Row contents, two bits per input |
| arr_in | input | 22 | Array inputs, dedicated or fed back |
| sum_out | output | 10 | OR of the eight logic terms per output |
| oe_out | output | 10 | Enable term per output |

## Verification
The bench builds the block with its default values: 22 inputs, 10 outputs and eight terms per output. This means the full 90-row map is exercised, along with the unused row codes 90 to 127 that the 7-bit row index allows. A behavioural model of the map is updated at each edge and compared with both output vectors in every cycle. Random sparse rows and random inputs are used, and one phase feeds ten outputs back into the array as a small state machine. Directed steps cover single-literal terms, all-open rows, both-literal rows, erase colliding with a write, and input changes made in the middle of a cycle.

// File: rtl/pal_pkg.sv
// Shared definitions for the AND-OR array.
// Assumes two fuse bits per input, with the true-literal bit above the inverted-literal bit.
package pal_pkg;

    // Connection choice of one term for one input: {true bit, inverted bit}.
    typedef enum logic [1:0] {
        LIT_NONE = 2'b00,
        LIT_COMP = 2'b01,
        LIT_TRUE = 2'b10,
        LIT_BOTH = 2'b11
    } lit_sel_e;

    // Row index of term k of output o when each output owns rows_per_out rows.
    function automatic int row_of(input int o, input int k, input int rows_per_out);
        return o * rows_per_out + k;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
// Connection map storage: one register row per product term.
// Assumes writes address whole rows. An index at or beyond ROWS matches no row and is dropped.
// Erase has priority over a write in the same cycle.
module pal_fuse_store #(
    parameter int N_IN  = 22,
    parameter int ROWS  = 90,
    localparam int COLS  = 2 * N_IN,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   erase,
    input  logic [ROW_W-1:0]       wr_row,
    input  logic [COLS-1:0]        wr_data,
    output logic [ROWS*COLS-1:0]   fuse_flat
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] row_q;

        // Hold one term row: erased on reset or erase, replaced on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || erase) begin
                row_q <= '1;
            end else if (wr_en && (wr_row == ROW_W'(r))) begin
                row_q <= wr_data;
            end
        end

        assign fuse_flat[r*COLS +: COLS] = row_q;
    end

endmodule

// File: rtl/pal_term_row.sv
// One product term: ANDs every literal that its connection row selects.
// Assumes the encoding of pal_pkg::lit_sel_e. A row with no connections yields 1.
module pal_term_row #(
    parameter int N_IN = 22,
    localparam int COLS = 2 * N_IN
) (
    input  logic [COLS-1:0] fuse_row,
    input  logic [N_IN-1:0] lit_in,
    output logic            term_hit
);
    import pal_pkg::*;

    // Evaluate the AND of the selected literals.
    always_comb begin
        term_hit = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            case (lit_sel_e'(fuse_row[2*i +: 2]))
                LIT_NONE: ;
                LIT_TRUE: if (!lit_in[i]) term_hit = 1'b0;
                LIT_COMP: if (lit_in[i])  term_hit = 1'b0;
                default:  term_hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pal_or_plane.sv
// Fixed OR plane: groups term results per output into a sum and an enable.
// Assumes each output owns N_TERM logic rows followed by one enable row.
module pal_or_plane #(
    parameter int N_OUT  = 10,
    parameter int N_TERM = 8,
    localparam int RPO  = N_TERM + 1,
    localparam int ROWS = N_OUT * RPO
) (
    input  logic [ROWS-1:0]  term_hit,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_out
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sum_out[o] = |term_hit[o*RPO +: N_TERM];
        assign oe_out[o]  = term_hit[o*RPO + N_TERM];
    end

endmodule

// File: rtl/pal_and_or_array.sv
// Top of the programmable AND-OR array: stored connection map, term rows and OR plane.
// Assumes the map is written while the outputs are unused. Outputs are combinational from arr_in.
module pal_and_or_array #(
    parameter int N_IN   = 22,
    parameter int N_OUT  = 10,
    parameter int N_TERM = 8,
    localparam int COLS  = 2 * N_IN,
    localparam int RPO   = N_TERM + 1,
    localparam int ROWS  = N_OUT * RPO,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_erase,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [COLS-1:0]   cfg_data,
    input  logic [N_IN-1:0]   arr_in,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_out
);

    logic [ROWS*COLS-1:0] fuse_flat;
    logic [ROWS-1:0]      term_hit;

    pal_fuse_store #(.N_IN(N_IN), .ROWS(ROWS)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .erase     (cfg_erase),
        .wr_row    (cfg_row),
        .wr_data   (cfg_data),
        .fuse_flat (fuse_flat)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_term
        pal_term_row #(.N_IN(N_IN)) i_term (
            .fuse_row (fuse_flat[r*COLS +: COLS]),
            .lit_in   (arr_in),
            .term_hit (term_hit[r])
        );
    end

    pal_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) i_or (
        .term_hit (term_hit),
        .sum_out  (sum_out),
        .oe_out   (oe_out)
    );

endmodule

// File: rtl/pal_and_or_array_chk.sv
// Checker for pal_and_or_array: relates configuration commands to the outputs one cycle later.
// Assumes it is bound to the top module and sees its ports.
module pal_and_or_array_chk #(
    parameter int N_IN   = 22,
    parameter int N_OUT  = 10,
    parameter int N_TERM = 8,
    localparam int COLS  = 2 * N_IN,
    localparam int RPO   = N_TERM + 1,
    localparam int ROWS  = N_OUT * RPO,
    localparam int ROW_W = $clog2(ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_erase,
    input logic [ROW_W-1:0]  cfg_row,
    input logic [COLS-1:0]   cfg_data,
    input logic [N_IN-1:0]   arr_in,
    input logic [N_OUT-1:0]  sum_out,
    input logic [N_OUT-1:0]  oe_out
);

    AST_ERASE_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (sum_out == '0) && (oe_out == '0)); // R8

    AST_BAD_ROW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_erase && (int'(cfg_row) >= ROWS))
        |=> (!$stable(arr_in) || ($stable(sum_out) && $stable(oe_out)))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cfg_erase)
        |=> (!$stable(arr_in) || ($stable(sum_out) && $stable(oe_out)))); // R11

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        localparam int EN_ROW = o * RPO + N_TERM;
        localparam int LG_ROW = o * RPO;

        AST_OPEN_ENABLE_ROW_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_erase && (int'(cfg_row) == EN_ROW) && (cfg_data == '0))
            |=> oe_out[o]); // R4

        AST_OPEN_LOGIC_ROW_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_erase && (int'(cfg_row) == LG_ROW) && (cfg_data == '0))
            |=> sum_out[o]); // R6
    end

endmodule

bind pal_and_or_array pal_and_or_array_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)
) i_chk (.*);

// File: tb/test_pal_and_or_array.sv
`timescale 1ns/1ps
// Bench for pal_and_or_array: a behavioural map model is compared with the outputs every cycle.
module test_pal_and_or_array;

    localparam int NI = 22;
    localparam int NO = 10;
    localparam int NT = 8;
    localparam int NR = NO * (NT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_erase = 1'b0;
    logic [6:0]    cfg_row = '0;
    logic [43:0]   cfg_data = '0;
    logic [21:0]   arr_in = '0;
    logic [9:0]    sum_out;
    logic [9:0]    oe_out;

    logic [43:0]   mdl [NR];
    int            n_cmp = 0;
    int            n_bad = 0;
    string         tag = "R1";
    bit            run_cmp = 1'b0;
    bit            done = 1'b0;

    pal_and_or_array i_pal_and_or_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
        .cfg_row(cfg_row), .cfg_data(cfg_data), .arr_in(arr_in),
        .sum_out(sum_out), .oe_out(oe_out)
    );

    always #2.5 clk = ~clk;

    // Model term: every tied literal must hold (R2, R3, R4).
    function automatic bit term_val(input logic [43:0] r, input logic [21:0] x);
        for (int i = 0; i < NI; i++) begin
            if (r[2*i+1] && !x[i]) return 1'b0;
            if (r[2*i]   &&  x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Model outputs from the row layout o*9+k (R5, R6).
    function automatic logic [19:0] model_out(input logic [21:0] x);
        logic [9:0] s, e;
        s = '0; e = '0;
        for (int o = 0; o < NO; o++) begin
            for (int k = 0; k < NT; k++) s[o] = s[o] | term_val(mdl[o*(NT+1)+k], x);
            e[o] = term_val(mdl[o*(NT+1)+NT], x);
        end
        return {e, s};
    endfunction

    // Model map update at each edge: reset and erase first, then in-range writes (R1, R7, R8, R9).
    always @(posedge clk) begin
        if (!rst_n || cfg_erase) begin
            for (int r = 0; r < NR; r++) mdl[r] = '1;
        end else if (cfg_we && (int'(cfg_row) < NR)) begin
            mdl[cfg_row] = cfg_data;
        end
    end

    task automatic compare(input string t);
        logic [19:0] exp_v;
        exp_v = model_out(arr_in);
        n_cmp++;
        if ({oe_out, sum_out} !== exp_v) begin
            n_bad++;
            $display("FAIL %s: oe/sum actual %h expected %h (arr_in %h)", t,
                     {oe_out, sum_out}, exp_v, arr_in);
        end
    endtask

    // Compare once per cycle, away from the rising edge.
    always @(negedge clk) if (run_cmp && !done) compare(tag);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int row, input logic [43:0] d);
        cfg_we = 1'b1; cfg_row = 7'(row); cfg_data = d;
        step();
        cfg_we = 1'b0;
    endtask

    function automatic logic [43:0] one_lit(input int i, input logic [1:0] code);
        logic [43:0] d;
        d = '0;
        d[2*i +: 2] = code;
        return d;
    endfunction

    function automatic logic [43:0] rand_row();
        logic [43:0] d;
        for (int i = 0; i < NI; i++) begin
            int p;
            p = $urandom_range(0, 99);
            d[2*i +: 2] = (p < 82) ? 2'b00 : (p < 90) ? 2'b10 : (p < 99) ? 2'b01 : 2'b11;
        end
        return d;
    endfunction

    initial begin
        step(); step();
        rst_n = 1'b1;
        run_cmp = 1'b1;
        // R1: erased map after reset, outputs all zero.
        tag = "R1"; step();
        if (sum_out !== '0 || oe_out !== '0) begin
            n_bad++; $display("FAIL R1: actual %h expected 0", {oe_out, sum_out});
        end
        n_cmp++;

        // R2 R5 R7: output 3 term 2 needs input 5 true.
        tag = "R2";
        wr(3*9+2, one_lit(5, 2'b10));
        arr_in = 22'h20; #1; compare("R7");
        if (sum_out[3] !== 1'b1) begin n_bad++; $display("FAIL R5: sum3 actual %b expected 1", sum_out[3]); end
        n_cmp++;
        arr_in = 22'h0; step();
        // R2: output 6 enable needs input 21 false.
        wr(6*9+8, one_lit(21, 2'b01));
        arr_in = 22'h0; #1; compare("R2");
        arr_in = 22'h200000; #1; compare("R2");
        // R4: all-open enable row of output 0 is 1.
        tag = "R4"; wr(8, '0); step();
        // R3: both literals on input 0 keep output 9 term 0 low.
        tag = "R3"; wr(81, one_lit(0, 2'b11)); arr_in = 22'h1; step(); arr_in = 22'h0; step();
        // R9: rows 90 and 127 take no data.
        tag = "R9"; wr(90, '0); wr(127, '0); step();
        if (sum_out[9] !== 1'b0) begin n_bad++; $display("FAIL R9: sum9 actual %b expected 0", sum_out[9]); end
        n_cmp++;
        // R8: erase beats a simultaneous write.
        tag = "R8"; cfg_erase = 1'b1; cfg_we = 1'b1; cfg_row = 7'd0; cfg_data = '0;
        step(); cfg_erase = 1'b0; cfg_we = 1'b0; step();
        if (sum_out !== '0 || oe_out !== '0) begin
            n_bad++; $display("FAIL R8: actual %h expected 0", {oe_out, sum_out});
        end
        n_cmp++;

        // R6 R7 R11: random sparse rows and random inputs.
        tag = "R6";
        for (int r = 0; r < NR; r++) wr(r, rand_row());
        for (int c = 0; c < 600; c++) begin
            if ($urandom_range(0, 3) == 0) begin
                cfg_we = 1'b1; cfg_row = 7'($urandom_range(0, 127)); cfg_data = rand_row();
            end else begin
                cfg_we = 1'b0;
            end
            arr_in = 22'($urandom);
            step();
        end
        cfg_we = 1'b0;

        // R10: feedback of sums to inputs 0..9 as a state machine; mid-cycle input change.
        tag = "R10";
        for (int c = 0; c < 200; c++) begin
            arr_in = {12'($urandom), sum_out};
            @(negedge clk); #0.5;
            arr_in[21] = ~arr_in[21]; #0.5;
            compare("R10");
            step();
        end

        // R11: idle cycles with steady inputs.
        tag = "R11"; for (int c = 0; c < 20; c++) step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule